// File: doc/BRIEF.md
# SHA-512 Two-Round Compression Datapath

This block advances a SHA-512 working state by two compression rounds in one clock cycle. The eight 64-bit working variables arrive split across two packed 256-bit words. One word carries the "leading" variables A, B, E and F. The other carries the "trailing" variables C, D, G and H. A 128-bit word supplies two round addends. Each addend is the sum of a message-schedule word and its round constant, already formed by the caller.

The result is the leading group after the two rounds, packed in the same layout as the leading input. After two rounds the trailing group equals the leading input, because each round shifts the variables down. A caller can therefore chain calls by feeding the previous leading input back as the next trailing input. Forty chained calls make up one full 80-round block.

The block has one output register behind a valid/ready handshake, so it fits directly into a streaming pipeline. Message expansion, constant storage and block sequencing are left to the caller.

Top module: `sha512_dual_round`

## Requirements
- R1: The leading input `abef_i` packs A in bits [255:192], B in [191:128], E in [127:64] and F in [63:0]. The trailing input `cdgh_i` packs C in [255:192], D in [191:128], G in [127:64] and H in [63:0].
- R2: The first round uses `wk_i[63:0]` as its addend and the second round uses `wk_i[127:64]`.
- R3: Each round computes T1 = H + S1(E) + Ch(E,F,G) + WK, new A = T1 + S0(A) + Maj(A,B,C) and new E = D + T1, with every sum taken modulo 2^64. S0 XORs the 64-bit right rotations of its argument by 28, 34 and 39. S1 XORs the rotations by 14, 18 and 41. Ch(e,f,g) = (e&f)^(~e&g) and Maj(a,b,c) = (a&b)^(a&c)^(b&c).
- R4: In each round the other variables shift: the old A becomes B, old B becomes C, old C becomes D, old E becomes F, old F becomes G and old G becomes H. After two rounds, the output B equals A after round one and the output F equals E after round one.
- R5: `abef_o` packs the post-round A, B, E and F in the same bit positions as `abef_i`. C, D, G and H are not output.
- R6: An input is accepted on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. `out_valid_o` is high in the cycle after an accepted input and low in the cycle after an edge with `in_ready_o` high and no input accepted.
- R7: `in_ready_o` is high whenever `out_valid_o` is low or `out_ready_i` is high, and low otherwise.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `abef_o` hold their values, and input changes have no effect on them.
- R9: Asserting `rst_ni` low clears `out_valid_o` at once, which leaves `in_ready_o` high.
- R10: Chaining 40 calls over the padded one-block message "abc", and adding the initial hash words, yields the standard SHA-512 digest of "abc".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input operands valid |
| in_ready_o | output | 1 | Block can accept an input this cycle |
| abef_i | input | 256 | Leading state group {A,B,E,F} |
| cdgh_i | input | 256 | Trailing state group {C,D,G,H} |
| wk_i | input | 128 | Round addends {second, first} |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts the result |
| abef_o | output | 256 | Updated leading group {A,B,E,F} |

## Verification
The bench builds the block with its default of two rounds per call and 64-bit words, which is the shape that a chained 80-round block needs. With these values, 40 chained calls reach a known digest, which tests the round function against an external result rather than only against the bench model. Random operands cover every adder's carry chain. Directed cases separate the two addend lanes, apply back-pressure while the inputs change, and apply reset while a result is pending.

// File: rtl/sha512_rnd_pkg.sv
package sha512_rnd_pkg;
  localparam int unsigned QW = 64;

  typedef logic [QW-1:0] qword_t;

  typedef struct packed {
    qword_t a, b, c, d, e, f, g, h;
  } wstate_t;

  function automatic qword_t rotr(input qword_t x, input int unsigned n);
    return (x >> n) | (x << (QW - n));
  endfunction

  function automatic qword_t big_s0(input qword_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic qword_t big_s1(input qword_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic qword_t choose(input qword_t e, input qword_t f, input qword_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic qword_t majority(input qword_t a, input qword_t b, input qword_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha512_round_step.sv
module sha512_round_step
  import sha512_rnd_pkg::*;
(
  input  wstate_t st_i,
  input  qword_t  wk_i,
  output wstate_t st_o
);
  qword_t t1;
  qword_t t2;

  always_comb begin
    t1 = st_i.h + big_s1(st_i.e) + choose(st_i.e, st_i.f, st_i.g) + wk_i;
    t2 = big_s0(st_i.a) + majority(st_i.a, st_i.b, st_i.c);
    st_o.a = t1 + t2;
    st_o.b = st_i.a;
    st_o.c = st_i.b;
    st_o.d = st_i.c;
    st_o.e = st_i.d + t1;
    st_o.f = st_i.e;
    st_o.g = st_i.f;
    st_o.h = st_i.g;
  end
endmodule

// File: rtl/sha512_out_stage.sv
module sha512_out_stage #(
  parameter int unsigned DW = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] data_o
);
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          fire;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign fire        = in_valid_i && in_ready_o;
  assign out_valid_o = valid_q;
  assign data_o      = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (in_ready_o) valid_q <= in_valid_i;
      if (fire)       data_q  <= data_i;
    end
  end

  a_r6_accept_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r6_idle_clears_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && in_ready_o) |=> !out_valid_o);

  a_r8_hold_when_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(data_o)));
endmodule

// File: rtl/sha512_dual_round.sv
module sha512_dual_round
  import sha512_rnd_pkg::*;
#(
  parameter int unsigned ROUNDS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [4*QW-1:0]      abef_i,
  input  logic [4*QW-1:0]      cdgh_i,
  input  logic [ROUNDS*QW-1:0] wk_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [4*QW-1:0]      abef_o
);
  localparam int unsigned PW = 4 * QW;

  wstate_t         st [ROUNDS+1];
  logic [PW-1:0]   packed_res;
  qword_t          pre_a;
  qword_t          pre_e;

  // Operand unpacking: fixed qword slots.
  assign st[0] = '{a: abef_i[4*QW-1:3*QW], b: abef_i[3*QW-1:2*QW],
                   e: abef_i[2*QW-1:QW],   f: abef_i[QW-1:0],
                   c: cdgh_i[4*QW-1:3*QW], d: cdgh_i[3*QW-1:2*QW],
                   g: cdgh_i[2*QW-1:QW],   h: cdgh_i[QW-1:0]};

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    sha512_round_step u_step (
      .st_i (st[r]),
      .wk_i (wk_i[r*QW +: QW]),
      .st_o (st[r+1])
    );
  end

  assign packed_res = {st[ROUNDS].a, st[ROUNDS].b, st[ROUNDS].e, st[ROUNDS].f};
  assign pre_a      = st[ROUNDS-1].a;
  assign pre_e      = st[ROUNDS-1].e;

  sha512_out_stage #(.DW(PW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .data_i      (packed_res),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .data_o      (abef_o)
  );

  a_r4_b_from_prior_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (abef_o[3*QW-1:2*QW] == $past(pre_a)));

  a_r4_f_from_prior_e: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (abef_o[QW-1:0] == $past(pre_e)));

  a_r7_ready_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
endmodule

// File: tb/sha512_dual_round_test.sv
module sha512_dual_round_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] abef = '0;
  logic [255:0] cdgh = '0;
  logic [127:0] wk = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] abef_res;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sha512_dual_round uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .abef_i(abef), .cdgh_i(cdgh), .wk_i(wk), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .abef_o(abef_res)
  );

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [255:0] ref_two(input logic [255:0] p, input logic [255:0] q,
                                           input logic [127:0] w);
    logic [63:0] a, b, c, d, e, f, g, h, t1, t2;
    a = p[255:192]; b = p[191:128]; e = p[127:64]; f = p[63:0];
    c = q[255:192]; d = q[191:128]; g = q[127:64]; h = q[63:0];
    for (int i = 0; i < 2; i++) begin
      t1 = h + (rr(e,14) ^ rr(e,18) ^ rr(e,41)) + ((e & f) ^ (~e & g)) + w[i*64 +: 64];
      t2 = (rr(a,28) ^ rr(a,34) ^ rr(a,39)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + t1;
      d = c; c = b; b = a; a = t1 + t2;
    end
    return {a, b, e, f};
  endfunction

  function automatic int nth_prime(input int n);
    int cnt = 0;
    for (int v = 2; v < 1000; v++) begin
      bit isp = 1'b1;
      for (int k = 2; k * k <= v; k++) if (v % k == 0) isp = 1'b0;
      if (isp) begin
        if (cnt == n) return v;
        cnt++;
      end
    end
    return 0;
  endfunction

  // Fractional bits of cube / square roots computed by bitwise integer root.
  function automatic logic [63:0] k_const(input int idx);
    logic [255:0] n, r, t;
    n = 256'(nth_prime(idx)) << 192;
    r = '0;
    for (int b = 79; b >= 0; b--) begin
      t = r | (256'd1 << b);
      if (t * t * t <= n) r = t;
    end
    return r[63:0];
  endfunction

  function automatic logic [63:0] h_init(input int idx);
    logic [255:0] n, r, t;
    n = 256'(nth_prime(idx)) << 128;
    r = '0;
    for (int b = 70; b >= 0; b--) begin
      t = r | (256'd1 << b);
      if (t * t <= n) r = t;
    end
    return r[63:0];
  endfunction

  task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [255:0] p, input logic [255:0] q, input logic [127:0] w,
                      output logic [255:0] res);
    @(negedge clk);
    in_valid = 1'b1; abef = p; cdgh = q; wk = w; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = abef_res;
    chk("R6 valid after accept", {255'd0, out_valid}, 256'd1);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] res, p, q, first_res;
    logic [127:0] w;
    logic [63:0] hv [8];
    logic [63:0] wsch [80];
    logic [63:0] kk [80];
    void'($urandom(32'h1f2e3d4c));

    // R9 reset state
    #3;
    chk("R9 valid in reset", {255'd0, out_valid}, 256'd0);
    chk("R9 ready in reset", {255'd0, in_ready}, 256'd1);
    @(negedge clk); rst_ni = 1'b1;

    // R3 R5 all-zero state stays zero
    xfer('0, '0, '0, res);
    chk("R3 R5 zero state", res, '0);

    // R2 lane separation
    p = {r64(), r64(), r64(), r64()}; q = {r64(), r64(), r64(), r64()};
    w = {64'd0, 64'h0123456789abcdef};
    xfer(p, q, w, res);
    chk("R2 low lane addend", res, ref_two(p, q, w));
    w = {64'h0123456789abcdef, 64'd0};
    xfer(p, q, w, res);
    chk("R2 high lane addend", res, ref_two(p, q, w));

    // R1 R4 all-ones corner
    xfer({256{1'b1}}, {256{1'b1}}, {128{1'b1}}, res);
    chk("R1 R4 all ones", res, ref_two({256{1'b1}}, {256{1'b1}}, {128{1'b1}}));

    // R1 R3 R4 R5 random
    for (int i = 0; i < 200; i++) begin
      p = {r64(), r64(), r64(), r64()}; q = {r64(), r64(), r64(), r64()};
      w = {r64(), r64()};
      xfer(p, q, w, res);
      chk("R3 R4 random rounds", res, ref_two(p, q, w));
    end

    // R6 idle drops valid
    @(negedge clk);
    chk("R6 idle clears valid", {255'd0, out_valid}, 256'd0);

    // R7 R8 back-pressure with changing inputs
    p = {r64(), r64(), r64(), r64()}; q = {r64(), r64(), r64(), r64()}; w = {r64(), r64()};
    in_valid = 1'b1; abef = p; cdgh = q; wk = w; out_ready = 1'b0;
    first_res = ref_two(p, q, w);
    @(negedge clk);
    chk("R7 ready low when stalled", {255'd0, in_ready}, 256'd0);
    p = {r64(), r64(), r64(), r64()}; abef = p;
    @(negedge clk);
    chk("R8 held valid", {255'd0, out_valid}, 256'd1);
    chk("R8 held data", abef_res, first_res);
    @(negedge clk);
    chk("R8 held data again", abef_res, first_res);
    out_ready = 1'b1;
    #0.5;
    chk("R7 ready with out_ready", {255'd0, in_ready}, 256'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 R8 second result", abef_res, ref_two(p, q, w));

    // R9 asynchronous reset with result pending
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_ni = 1'b0;
    #0.5;
    chk("R9 reset clears valid", {255'd0, out_valid}, 256'd0);
    chk("R9 ready after reset", {255'd0, in_ready}, 256'd1);
    @(negedge clk); rst_ni = 1'b1; out_ready = 1'b1;

    // R10 full block of "abc"
    for (int t = 0; t < 80; t++) kk[t] = k_const(t);
    for (int t = 0; t < 8; t++) hv[t] = h_init(t);
    for (int t = 0; t < 16; t++) wsch[t] = '0;
    wsch[0] = 64'h6162638000000000;
    wsch[15] = 64'd24;
    for (int t = 16; t < 80; t++)
      wsch[t] = (rr(wsch[t-2],19) ^ rr(wsch[t-2],61) ^ (wsch[t-2] >> 6)) + wsch[t-7]
              + (rr(wsch[t-15],1) ^ rr(wsch[t-15],8) ^ (wsch[t-15] >> 7)) + wsch[t-16];
    p = {hv[0], hv[1], hv[4], hv[5]};
    q = {hv[2], hv[3], hv[6], hv[7]};
    begin
      logic [255:0] mp, mq, mres;
      mp = p; mq = q;
      for (int j = 0; j < 40; j++) begin
        w = {wsch[2*j+1] + kk[2*j+1], wsch[2*j] + kk[2*j]};
        xfer(p, q, w, res);
        mres = ref_two(mp, mq, w);
        q = p; p = res;
        mq = mp; mp = mres;
      end
      chk("R10 chain matches model", p, mp);
    end
    chk("R10 digest words 0-3",
        {p[255:192] + hv[0], p[191:128] + hv[1], q[255:192] + hv[2], q[191:128] + hv[3]},
        256'hddaf35a193617abacc417349ae20413112e6fa4e89a97ea20a9eeee64b55d39a);
    chk("R10 digest words 4-7",
        {p[127:64] + hv[4], p[63:0] + hv[5], q[127:64] + hv[6], q[63:0] + hv[7]},
        256'h2192992a274fc1a836ba3c23a3feebbd454d4423643ce80e2a9ac94fa54ca49f);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule